// File: doc/BRIEF.md
# Alternating-Phase Accumulating Calculator

This block is a sequential calculator whose first operand is its own stored result. Each calculation combines that stored value with a new operand. A two-bit select picks the operation. The new value is written back, so a series of operations forms a running chain without any external storage.

The block sets its own pace. An internal phase bit alternates on every clock, and only every other clock edge accepts work. The result of an accepted operation appears on the output in the next cycle, with a flag raised beside it. In the cycle after that, the output drops to zero and the flag clears. Inputs that arrive while the block is in its idle phase are discarded. A synchronous reset clears the stored value and restarts the rhythm from a known phase. The surrounding logic only has to present an operand at the right moment and pick up the result.

Top module: `calc_alt_accum`

## Requirements
- R1: While `rst` is high at a rising edge, the next cycle shows `result_o` = 0 and `out_valid_o` = 0, and the stored result becomes 0.
- R2: The first edge at which `rst` is sampled low accepts no operation. The edge after it is the first accepting edge, and from then on accepting and idle edges strictly alternate.
- R3: After an accepting edge, `result_o` carries the new result and `out_valid_o` is 1 for one cycle. After an idle edge, `result_o` is 0 and `out_valid_o` is 0.
- R4: The left operand of every operation is the previously stored result, and the new result replaces it.
- R5: Select 2'b00 adds the operand and select 2'b01 subtracts it (stored minus operand). Both are modulo 2^32.
- R6: Select 2'b10 multiplies and keeps the low 32 bits of the product.
- R7: Select 2'b11 divides the stored result by the operand, both unsigned, and keeps the truncated quotient.
- R8: Dividing by zero yields 32'hFFFF_FFFF in the same single cycle, and that value is stored.
- R9: The operand and select presented at an idle edge change neither the stored result nor any later output.
- R10: A reset applied mid-run discards the stored result and restarts the phase, so the block behaves exactly as it does after the first reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| operand_i | input | 32 | Right-hand operand |
| op_sel_i | input | 2 | Operation select: 00 add, 01 subtract, 10 multiply, 11 divide |
| result_o | output | 32 | Result of the last accepted operation, or zero after an idle edge |
| out_valid_o | output | 1 | High while `result_o` carries a result |

## Verification
The hardest case to reach from the ports is showing that an idle edge truly leaves the stored value untouched. The stored value itself is never visible, and the output reads zero in that cycle anyway. The bench therefore presents large, varied operands with every select value at each idle edge. It then follows with an accepting add of zero, which replays the stored value onto `result_o` so the bench can compare it with its own model. The divide-by-zero path is reached in the same way: a chain of operations first builds a known nonzero stored value.

// File: rtl/calc_pkg.sv
package calc_pkg;

    localparam int DATA_W = 32;

    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_SUB = 2'b01,
        OP_MUL = 2'b10,
        OP_DIV = 2'b11
    } calc_op_e;

    function automatic calc_op_e decode_op(input logic [1:0] sel);
        return calc_op_e'(sel);
    endfunction

endpackage

// File: rtl/calc_phase_gen.sv
module calc_phase_gen (
    input  logic clk,
    input  logic rst,
    output logic accept_o
);
    logic phase_q;

    always_ff @(posedge clk) begin
        if (rst) phase_q <= 1'b0;
        else     phase_q <= ~phase_q;
    end

    assign accept_o = phase_q;

    AST_PHASE_RESET: assert property (@(posedge clk) rst |=> !accept_o); // R2
    AST_PHASE_FALL:  assert property (@(posedge clk) disable iff (rst) accept_o |=> !accept_o); // R2
    AST_PHASE_RISE:  assert property (@(posedge clk) disable iff (rst) !accept_o |=> accept_o); // R2

endmodule

// File: rtl/calc_divider.sv
module calc_divider #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] num_i,
    input  logic [WIDTH-1:0] den_i,
    output logic [WIDTH-1:0] quo_o
);
    logic [WIDTH-1:0] rem [WIDTH];

    assign rem[0] = '0;

    for (genvar i = 0; i < WIDTH; i++) begin : g_step
        logic [WIDTH:0] trial;
        logic           ge;
        assign trial = {rem[i], num_i[WIDTH-1-i]};
        assign ge    = (trial >= {1'b0, den_i});
        assign quo_o[WIDTH-1-i] = ge;
        if (i < WIDTH - 1) begin : g_rem
            assign rem[i+1] = ge ? (trial[WIDTH-1:0] - den_i) : trial[WIDTH-1:0];
        end
    end

endmodule

// File: rtl/calc_alu.sv
module calc_alu
    import calc_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] lhs_i,
    input  logic [WIDTH-1:0] rhs_i,
    input  calc_op_e         op_i,
    output logic [WIDTH-1:0] res_o
);
    logic [WIDTH-1:0] quo;

    calc_divider #(.WIDTH(WIDTH)) u_div (
        .num_i (lhs_i),
        .den_i (rhs_i),
        .quo_o (quo)
    );

    always_comb begin
        unique case (op_i)
            OP_ADD:  res_o = lhs_i + rhs_i;
            OP_SUB:  res_o = lhs_i - rhs_i;
            OP_MUL:  res_o = lhs_i * rhs_i;
            default: res_o = quo;
        endcase
    end

    always_comb begin
        if (!$isunknown({op_i, rhs_i, lhs_i}) && op_i == OP_DIV && rhs_i == '0)
            AST_DIV_ZERO: assert (res_o == '1); // R8
    end

endmodule

// File: rtl/calc_alt_accum.sv
module calc_alt_accum
    import calc_pkg::*;
#(
    parameter int WIDTH = calc_pkg::DATA_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] operand_i,
    input  logic [1:0]       op_sel_i,
    output logic [WIDTH-1:0] result_o,
    output logic             out_valid_o
);
    logic             accept;
    logic [WIDTH-1:0] alu_res;
    logic [WIDTH-1:0] acc_q;
    logic [WIDTH-1:0] out_q;
    logic             vld_q;

    calc_phase_gen u_phase (
        .clk      (clk),
        .rst      (rst),
        .accept_o (accept)
    );

    calc_alu #(.WIDTH(WIDTH)) u_alu (
        .lhs_i (acc_q),
        .rhs_i (operand_i),
        .op_i  (decode_op(op_sel_i)),
        .res_o (alu_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            out_q <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= accept;
            if (accept) begin
                acc_q <= alu_res;
                out_q <= alu_res;
            end else begin
                out_q <= '0;
            end
        end
    end

    assign result_o    = out_q;
    assign out_valid_o = vld_q;

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (result_o == '0 && !out_valid_o && acc_q == '0)); // R1
    AST_OUT_MATCH:   assert property (@(posedge clk) disable iff (rst)
        accept |=> (out_valid_o && result_o == acc_q)); // R3
    AST_OUT_ZERO:    assert property (@(posedge clk) disable iff (rst)
        !accept |=> (!out_valid_o && result_o == '0)); // R3
    AST_IDLE_HOLD:   assert property (@(posedge clk) disable iff (rst)
        !accept |=> $stable(acc_q)); // R9
    AST_DIV_ZERO_OUT: assert property (@(posedge clk) disable iff (rst)
        (accept && op_sel_i == 2'b11 && operand_i == '0) |=> result_o == '1); // R8

endmodule

// File: tb/sim_calc_alt_accum.sv
module sim_calc_alt_accum;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] operand_i = '0;
    logic [1:0]  op_sel_i = '0;
    logic [31:0] result_o;
    logic        out_valid_o;

    int checks = 0;
    int failures = 0;
    logic [31:0] model = '0;

    always #10 clk = ~clk;

    calc_alt_accum u0 (
        .clk         (clk),
        .rst         (rst),
        .operand_i   (operand_i),
        .op_sel_i    (op_sel_i),
        .result_o    (result_o),
        .out_valid_o (out_valid_o)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h expected=%h", req, got, exp);
        end
    endtask

    function automatic logic [31:0] ref_op(input logic [31:0] a, input logic [31:0] b,
                                           input logic [1:0] s);
        logic [63:0] p;
        case (s)
            2'b00: return a + b;
            2'b01: return a - b;
            2'b10: begin p = {32'd0, a} * {32'd0, b}; return p[31:0]; end
            default: return (b == 0) ? 32'hFFFF_FFFF : a / b;
        endcase
    endfunction

    // Leaves the bench at a falling edge with the next rising edge accepting.
    task automatic do_reset(input string req);
        @(negedge clk);
        rst = 1'b1;
        operand_i = 32'hDEAD_BEEF;
        op_sel_i = 2'b10;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk({req, " result in reset"}, result_o, 32'd0);
            chk({req, " valid in reset"}, {31'd0, out_valid_o}, 32'd0);
        end
        rst = 1'b0;
        @(negedge clk);
        chk("R2 no accept at first edge", {31'd0, out_valid_o}, 32'd0);
        chk("R2 zero at first edge", result_o, 32'd0);
        model = '0;
    endtask

    // One accepting edge with (a, s), then one idle edge with junk inputs.
    task automatic pair(input string req, input logic [31:0] a, input logic [1:0] s,
                        input logic [31:0] ja, input logic [1:0] js);
        operand_i = a;
        op_sel_i = s;
        model = ref_op(model, a, s);
        @(negedge clk);
        chk({req, " R3 result"}, result_o, model);
        chk({req, " R3 valid high"}, {31'd0, out_valid_o}, 32'd1);
        operand_i = ja;
        op_sel_i = js;
        @(negedge clk);
        chk({req, " R3 idle zero"}, result_o, 32'd0);
        chk({req, " R3 valid low"}, {31'd0, out_valid_o}, 32'd0);
    endtask

    task automatic t_add_sub;
        pair("R5 add", 32'd10, 2'b00, 32'd99, 2'b00);
        pair("R5 sub wrap", 32'd15, 2'b01, 32'h1234_5678, 2'b11);
        chk("R5 wrap value", model, 32'hFFFF_FFFB);
        pair("R4 chain", 32'd20, 2'b00, 32'd0, 2'b11);
        chk("R4 chained value", model, 32'd15);
    endtask

    task automatic t_mul;
        pair("R6 mul", 32'd3, 2'b10, 32'hFFFF_FFFF, 2'b10);
        pair("R6 mul low bits", 32'h1000_0000, 2'b10, 32'd7, 2'b01);
        chk("R6 truncated", model, 32'hD000_0000);
    endtask

    task automatic t_div;
        pair("R7 div", 32'h10, 2'b11, 32'd0, 2'b11);
        chk("R7 quotient", model, 32'h0D00_0000);
        pair("R7 div trunc", 32'd7, 2'b11, 32'd1, 2'b00);
        pair("R8 div zero", 32'd0, 2'b11, 32'd5, 2'b01);
        chk("R8 all ones", model, 32'hFFFF_FFFF);
        pair("R8 stored", 32'd1, 2'b00, 32'd3, 2'b10);
        chk("R8 stored wrap", model, 32'd0);
    endtask

    task automatic t_idle_ignored;
        pair("R9 setup", 32'h0000_ABCD, 2'b00, 32'hFFFF_FFFF, 2'b10);
        pair("R9 replay after mul junk", 32'd0, 2'b00, 32'd0, 2'b11);
        pair("R9 replay after div0 junk", 32'd0, 2'b00, 32'h8000_0000, 2'b01);
        chk("R9 stored untouched", model, 32'h0000_ABCD);
    endtask

    task automatic t_midrun_reset;
        pair("R10 before reset", 32'd500, 2'b00, 32'd9, 2'b00);
        do_reset("R10");
        pair("R10 after reset", 32'd7, 2'b00, 32'd1, 2'b00);
        chk("R10 cleared", model, 32'd7);
    endtask

    initial begin
        do_reset("R1");
        t_add_sub();
        t_mul();
        t_div();
        t_idle_ignored();
        t_midrun_reset();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule